// File: doc/BRIEF.md
# I2C Target Register Interface

This block lets an I2C host read and write a byte-wide register space. The bus pins are handled open-drain style. SCL is only ever sampled. SDA is sampled and can be pulled low through an output enable, with the driven level tied to zero. Both lines are synchronised into the system clock domain, so the block runs with any system clock much faster than the bus. It keeps up with both 100 kbps and 400 kbps bus rates.

The 7-bit target address is the fixed pattern 110000 in bits 6..1, with bit 0 taken from a strap input. The first data byte of a write sets the register pointer. Later bytes are stored at successive locations. A read, which may follow a repeated START, returns bytes starting at the current pointer. The pointer steps by one after every byte in either direction.

Location 0 is not taken from the external register file. It is a read-only status byte built from live loss-of-signal and loss-of-lock inputs. All other locations go to a parallel register-file port: a registered write strobe, and a combinational read address and read data path.

Top module: `i2c_regif`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal {1,1,0,0,0,0,addr_strap}; bit 0 of the address byte selects read (1) or write (0).
- R2: On any other address the target leaves SDA released for the whole transaction, including later bytes, and issues no register write until the next START.
- R3: In a write, the first data byte after the address loads the register pointer. Each later byte produces exactly one single-cycle `rf_wr_en` pulse carrying the pointer as `rf_wr_addr` and the byte as `rf_wr_data`. The target acknowledges every data byte.
- R4: The register pointer increments by one after each data byte written (excluding the pointer byte) and after each byte read, so bursts reach consecutive locations.
- R5: A read returns bytes MSB first from the current pointer. Location 0 reads as status: bit 3 = `xtal_los`, bit 4 = `clkin_los`, bit 5 = `pll_lol[0]`, bit 6 = `pll_lol[1]`, bits 7 and 2..0 = 0.
- R6: A write aimed at location 0 produces no `rf_wr_en` pulse, but the pointer still advances.
- R7: After the host answers a read byte with NACK, the target releases SDA before the following STOP or START.
- R8: The target changes SDA only while SCL is low, outside of START and STOP handling. A STOP releases SDA.
- R9: After reset, SDA is released and no write strobe is active.
- R10: Transfers behave identically at 100 kbps and 400 kbps bus timing with a 100 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| sda_drv | output | 1 | Level driven when enabled, always 0 |
| addr_strap | input | 1 | Address bit 0 strap |
| xtal_los | input | 1 | Crystal reference loss of signal |
| clkin_los | input | 1 | External clock input loss of signal |
| pll_lol | input | 2 | Loss of lock, one bit per PLL |
| rf_wr_en | output | 1 | Register write strobe, one cycle |
| rf_wr_addr | output | 8 | Register write address |
| rf_wr_data | output | 8 | Register write data |
| rf_rd_addr | output | 8 | Register read address (current pointer) |
| rf_rd_data | input | 8 | Register read data, combinational from the file |

## Verification
Every bus event reaches the control logic about three system cycles after the line moves: two synchroniser stages plus one register for edge detection. An ACK or a data bit therefore appears on `sda_oe` roughly three cycles after the host drops SCL. A write strobe follows the eighth falling SCL edge after about the same delay. The bench moves SCL only on quarter-bit boundaries of 62 or 250 cycles and samples SDA in the middle of the high phase. Register contents and write-strobe counts are checked only after a transaction ends, so every result has settled well before it is read.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
    parameter int REG_AW = 8;
    parameter int BYTE_W = 8;
    parameter int CNT_W  = $clog2(BYTE_W + 1);
    parameter logic [5:0] ADDR_PREFIX = 6'b110000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e             st;
        logic [BYTE_W-1:0]   shift;
        logic [CNT_W-1:0]    cnt;
        logic [REG_AW-1:0]   ptr;
        logic                first;
        logic                rw;
        logic                nack;
        logic                oe;
        logic                wr_en;
        logic [REG_AW-1:0]   wr_addr;
        logic [BYTE_W-1:0]   wr_data;
        logic                scl_p;
        logic                sda_p;
    } regif_t;
endpackage

// File: rtl/i2c_regif_sync.sv
module i2c_regif_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_regif_rdmux.sv
module i2c_regif_rdmux
    import i2c_regif_pkg::*;
(
    input  logic [REG_AW-1:0] ptr,
    input  logic [BYTE_W-1:0] file_data,
    input  logic              xtal_los,
    input  logic              clkin_los,
    input  logic [1:0]        pll_lol,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] status;

    always_comb begin
        status    = '0;
        status[3] = xtal_los;
        status[4] = clkin_los;
        status[5] = pll_lol[0];
        status[6] = pll_lol[1];
        rd_byte   = (ptr == '0) ? status : file_data;
    end
endmodule

// File: rtl/i2c_regif.sv
module i2c_regif
    import i2c_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              sda_drv,
    input  logic              addr_strap,
    input  logic              xtal_los,
    input  logic              clkin_los,
    input  logic [1:0]        pll_lol,
    output logic              rf_wr_en,
    output logic [REG_AW-1:0] rf_wr_addr,
    output logic [BYTE_W-1:0] rf_wr_data,
    output logic [REG_AW-1:0] rf_rd_addr,
    input  logic [BYTE_W-1:0] rf_rd_data
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    logic [1:0]        bus_s;
    logic              scl_s, sda_s;
    logic              start_evt, stop_evt, scl_rise, scl_fall;
    logic              addr_hit;
    logic [BYTE_W-1:0] rd_byte;
    regif_t            r_q, r_d;

    i2c_regif_sync #(.STAGES(2), .W(2)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({scl_in, sda_in}),
        .q   (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2c_regif_rdmux u_rdmux (
        .ptr       (r_q.ptr),
        .file_data (rf_rd_data),
        .xtal_los  (xtal_los),
        .clkin_los (clkin_los),
        .pll_lol   (pll_lol),
        .rd_byte   (rd_byte)
    );

    // bus events on the synchronised lines
    assign start_evt = scl_s && r_q.scl_p && r_q.sda_p && !sda_s;
    assign stop_evt  = scl_s && r_q.scl_p && !r_q.sda_p && sda_s;
    assign scl_rise  = scl_s && !r_q.scl_p;
    assign scl_fall  = !scl_s && r_q.scl_p;
    assign addr_hit  = (r_q.shift[7:1] == {ADDR_PREFIX, addr_strap});

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.scl_p = scl_s;
        r_d.sda_p = sda_s;
        if (start_evt) begin
            r_d.st    = ST_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
            r_d.first = 1'b1;
        end else if (stop_evt) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == FULL_CNT) begin
                        if (addr_hit) begin
                            r_d.oe = 1'b1;
                            r_d.rw = r_q.shift[0];
                            r_d.st = ST_AACK;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.shift = rd_byte;
                            r_d.oe    = !rd_byte[BYTE_W-1];
                            r_d.st    = ST_RD;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == FULL_CNT) begin
                        r_d.oe = 1'b1;
                        r_d.st = ST_WACK;
                        if (r_q.first) begin
                            r_d.ptr   = r_q.shift;
                            r_d.first = 1'b0;
                        end else begin
                            r_d.wr_en   = (r_q.ptr != '0);
                            r_d.wr_addr = r_q.ptr;
                            r_d.wr_data = r_q.shift;
                            r_d.ptr     = r_q.ptr + 1'b1;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.oe  = 1'b0;
                            r_d.st  = ST_RACK;
                            r_d.ptr = r_q.ptr + 1'b1;
                        end else begin
                            r_d.shift = {r_q.shift[BYTE_W-2:0], 1'b0};
                            r_d.oe    = !r_q.shift[BYTE_W-2];
                            r_d.cnt   = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (r_q.nack) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.shift = rd_byte;
                            r_d.oe    = !rd_byte[BYTE_W-1];
                            r_d.cnt   = '0;
                            r_d.st    = ST_RD;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.scl_p <= 1'b1;
            r_q.sda_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe     = r_q.oe;
    assign sda_drv    = 1'b0;
    assign rf_wr_en   = r_q.wr_en;
    assign rf_wr_addr = r_q.wr_addr;
    assign rf_wr_data = r_q.wr_data;
    assign rf_rd_addr = r_q.ptr;

    // R6
    no_reg0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> rf_wr_addr != '0);

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> rf_rd_addr == $past(rf_wr_addr) + 1'b1);

    // R8
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
endmodule

// File: tb/test_i2c_regif.sv
module test_i2c_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_host = 1'b1;
    logic       sda_host = 1'b1;
    logic       sda_oe, sda_drv;
    logic       addr_strap = 1'b0;
    logic       xtal_los = 1'b0, clkin_los = 1'b0;
    logic [1:0] pll_lol = 2'b00;
    logic       rf_wr_en;
    logic [7:0] rf_wr_addr, rf_wr_data, rf_rd_addr, rf_rd_data;
    logic       sda_line, scl_line;

    logic [7:0] mem [0:255];
    int         wr_total = 0;
    int         wr_zero  = 0;
    int         checks = 0, errors = 0;
    int         q = 62;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = scl_host;
    assign sda_line = sda_host & ~(sda_oe & ~sda_drv);
    assign rf_rd_data = mem[rf_rd_addr];

    always @(posedge clk) begin
        if (rf_wr_en) begin
            mem[rf_wr_addr] <= rf_wr_data;
            wr_total <= wr_total + 1;
            if (rf_wr_addr == 8'h00) wr_zero <= wr_zero + 1;
        end
    end

    i2c_regif i_i2c_regif (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .sda_oe(sda_oe), .sda_drv(sda_drv), .addr_strap(addr_strap),
        .xtal_los(xtal_los), .clkin_los(clkin_los), .pll_lol(pll_lol),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_host = 1'b1; wq(q);
        scl_host = 1'b1; wq(q);
        sda_host = 1'b0; wq(q);
        scl_host = 1'b0; wq(q);
    endtask

    task automatic bus_stop;
        sda_host = 1'b0; wq(q);
        scl_host = 1'b1; wq(q);
        sda_host = 1'b1; wq(q);
    endtask

    task automatic put_bit(input logic b);
        sda_host = b;    wq(q);
        scl_host = 1'b1; wq(2 * q);
        scl_host = 1'b0; wq(q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_host = 1'b1; wq(q);
        scl_host = 1'b1; wq(q);
        ack = ~sda_line; wq(q);
        scl_host = 1'b0; wq(q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_host = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(q);
            scl_host = 1'b1; wq(q);
            b[i] = sda_line; wq(q);
            scl_host = 1'b0; wq(q);
        end
        put_bit(~give_ack);
        sda_host = 1'b1;
    endtask

    function automatic logic [7:0] dev_addr(input logic a0, input logic rd);
        return {6'b110000, a0, rd};
    endfunction

    function automatic logic [7:0] status_exp;
        return {1'b0, pll_lol[1], pll_lol[0], clkin_los, xtal_los, 3'b000};
    endfunction

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start;
        send_byte(dev_addr(addr_strap, 1'b0), a); chk("R1 write addr ack", a, 1);
        send_byte(p, a); chk("R3 pointer byte ack", a, 1);
    endtask

    task automatic t_reset;
        chk("R9 sda released after reset", sda_oe, 0);
        chk("R9 no write strobe after reset", rf_wr_en, 0);
    endtask

    task automatic t_write_burst(input int qq);
        logic a;
        int w0;
        q = qq;
        w0 = wr_total;
        set_ptr(8'h10);
        send_byte(8'hA1, a); chk("R3 data ack", a, 1);
        send_byte(8'hB2, a); chk("R3 data ack", a, 1);
        send_byte(8'h3C, a); chk("R3 data ack", a, 1);
        bus_stop;
        wq(10);
        chk("R3 reg 0x10", mem[8'h10], 8'hA1);
        chk("R4 reg 0x11", mem[8'h11], 8'hB2);
        chk("R4 reg 0x12", mem[8'h12], 8'h3C);
        chk("R3 strobe count", wr_total - w0, 3);
        chk("R8 sda released after stop", sda_oe, 0);
        chk("R10 untouched reg 0x13", mem[8'h13], 8'h00);
    endtask

    task automatic t_read_burst;
        logic a;
        logic [7:0] d;
        q = 62;
        set_ptr(8'h10);
        bus_start;
        send_byte(dev_addr(addr_strap, 1'b1), a); chk("R1 read addr ack", a, 1);
        recv_byte(1'b1, d); chk("R5 read 0x10", d, 8'hA1);
        recv_byte(1'b1, d); chk("R4 read 0x11", d, 8'hB2);
        recv_byte(1'b0, d); chk("R4 read 0x12", d, 8'h3C);
        wq(10);
        chk("R7 sda released after nack", sda_oe, 0);
        bus_stop;
    endtask

    task automatic t_status(input logic x, input logic c, input logic [1:0] l);
        logic a;
        logic [7:0] d;
        xtal_los = x; clkin_los = c; pll_lol = l;
        q = 62;
        set_ptr(8'h00);
        bus_start;
        send_byte(dev_addr(addr_strap, 1'b1), a); chk("R1 read addr ack", a, 1);
        recv_byte(1'b0, d); chk("R5 status byte", d, status_exp());
        bus_stop;
    endtask

    task automatic t_reg0_write;
        logic a;
        logic [7:0] d;
        int z0;
        z0 = wr_zero;
        q = 62;
        xtal_los = 1'b1; clkin_los = 1'b0; pll_lol = 2'b10;
        set_ptr(8'h00);
        send_byte(8'hFF, a); chk("R6 reg0 data still acked", a, 1);
        send_byte(8'h5A, a); chk("R6 next data ack", a, 1);
        bus_stop;
        wq(10);
        chk("R6 no strobe at location 0", wr_zero - z0, 0);
        chk("R6 file location 0 untouched", mem[8'h00], 8'hEE);
        chk("R6 pointer advanced to 1", mem[8'h01], 8'h5A);
        set_ptr(8'h00);
        bus_start;
        send_byte(dev_addr(addr_strap, 1'b1), a);
        recv_byte(1'b1, d); chk("R6 status unchanged by write", d, 8'h48);
        recv_byte(1'b0, d); chk("R4 read location 1", d, 8'h5A);
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic a;
        int w0;
        q = 62;
        w0 = wr_total;
        bus_start;
        send_byte(dev_addr(~addr_strap, 1'b0), a); chk("R2 wrong strap nack", a, 0);
        send_byte(8'h20, a); chk("R2 ignored byte nack", a, 0);
        send_byte(8'h77, a); chk("R2 ignored byte nack", a, 0);
        chk("R2 sda not driven", sda_oe, 0);
        bus_stop;
        wq(10);
        chk("R2 no strobe", wr_total - w0, 0);
        chk("R2 reg 0x20 untouched", mem[8'h20], 8'h00);
        bus_start;
        send_byte({7'b0101010, 1'b0}, a); chk("R2 foreign address nack", a, 0);
        bus_stop;
    endtask

    task automatic t_strap;
        logic a;
        q = 62;
        addr_strap = 1'b1;
        wq(4);
        bus_start;
        send_byte(dev_addr(1'b0, 1'b0), a); chk("R1 old address rejected", a, 0);
        bus_stop;
        set_ptr(8'h30);
        send_byte(8'h99, a);
        bus_stop;
        wq(10);
        chk("R1 strap 1 write", mem[8'h30], 8'h99);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0] = 8'hEE;
        wq(5);
        t_reset;
        rst_n = 1'b1;
        wq(5);
        t_reset;
        t_write_burst(250);
        t_read_burst;
        t_status(1'b1, 1'b0, 2'b01);
        t_status(1'b0, 1'b1, 2'b10);
        t_reg0_write;
        t_mismatch;
        t_strap;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 195000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule